// File: doc/BRIEF.md
# Interlaced Field Triple Buffer Manager

This block hands out frame buffer slots to a video writer and a video reader that run independently. For interlaced sources it keeps two separate triple-buffer rotations, one for even fields and one for odd fields. At every output frame start the reader takes the newest finished field of each parity. Each output picture is then woven from the two most recent half-fields, so the output refreshes once per input field rather than once per full frame. Memory traffic and the weave itself are handled elsewhere. The block only decides which slot each side may use.

The writer pulses a start strobe with the field parity, writes into the slot shown on `wr_buf_o`, and pulses a done strobe when the field is complete. The reader pulses a frame strobe at the start of each output frame and uses the two slot codes it receives for that whole frame. A progressive source uses only the even rotation, and both reader outputs then point at the same slot. Switching between interlaced and progressive mode returns every pointer to its reset state.

Slot codes are three bits wide. Bit 2 gives the parity rotation (0 even, 1 odd) and bits 1:0 give the slot inside that rotation (0 to 2).

Top module: `field_tbuf_mgr`

## Requirements
- R1: After reset `wr_buf_o`, `rd_even_o` and `rd_odd_o` are 0 and `rd_valid_o` is 0.
- R2: On `wr_start_i` the writer is given, in the rotation of its parity, the lowest slot number that is neither the slot the reader holds nor the latest finished slot. With no finished field yet, slots 1 and 2 count as those two, so the first pick is slot 0. `wr_buf_o` shows the pick from the next cycle on, with bit 2 equal to the field parity.
- R3: `wr_done_i` makes the slot being written the latest finished slot of its parity. The change becomes visible to the reader only at the next `rd_frame_i`, and the reader codes stay unchanged between two frame strobes.
- R4: While a field is being written, its slot never equals the slot the reader holds or the latest finished slot of the same parity.
- R5: Until both parities have finished at least once, the reader gets the single finished field on both `rd_even_o` and `rd_odd_o`. `rd_valid_o` rises at the first frame strobe after any field has finished.
- R6: In progressive mode (`interlaced_i` = 0) `wr_field_i` is ignored, all slots come from the even rotation, and `rd_even_o` equals `rd_odd_o`.
- R7: A change of `interlaced_i` returns all outputs and pointers to the R1 state one cycle later, and strobes in that cycle are ignored.
- R8: When `wr_done_i` and `rd_frame_i` occur in the same cycle, the reader takes the slot that has just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interlaced_i | input | 1 | 1 selects interlaced mode, 0 selects progressive mode |
| wr_start_i | input | 1 | Writer begins a field |
| wr_field_i | input | 1 | Parity of the field being started (0 even, 1 odd) |
| wr_done_i | input | 1 | Writer has finished the current field |
| rd_frame_i | input | 1 | Reader begins an output frame |
| wr_buf_o | output | 3 | Slot code the writer fills |
| rd_even_o | output | 3 | Slot code the reader uses for even lines |
| rd_odd_o | output | 3 | Slot code the reader uses for odd lines |
| rd_valid_o | output | 1 | Reader holds at least one finished field |

## Verification
The main function is tried with strictly alternating even and odd fields, with the reader running at the field rate and with the reader skipping a field. These patterns show whether each parity rotates on its own and whether the reader always takes the newest field of each parity. An odd-only start shows the single-field fallback. A done strobe in the same cycle as a frame strobe shows the same-cycle handover. Progressive runs with the parity input toggling show that the odd rotation is never touched, and a mode flip after activity shows the full return to the reset state.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int unsigned NUM_PAR = 2;
  typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_e;
endpackage

// File: rtl/tbm_slot_ring.sv
module tbm_slot_ring #(
  parameter int unsigned SLOTS = 3,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          done_i,
  input  logic          latch_i,
  output logic [SW-1:0] wr_slot_o,
  output logic [SW-1:0] done_slot_o,
  output logic [SW-1:0] rd_slot_o,
  output logic          rd_have_o
);
  localparam logic [SW-1:0] RD_INIT   = SW'(SLOTS - 1);
  localparam logic [SW-1:0] DONE_INIT = SW'(SLOTS - 2);

  logic [SW-1:0] wr_q, done_q, rd_q, pick;
  logic          have_q, rd_have_q;

  // lowest slot held by neither reader nor latest-finished
  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (SW'(i) != rd_q && SW'(i) != done_q) pick = SW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= '0;
      done_q    <= DONE_INIT;
      rd_q      <= RD_INIT;
      have_q    <= 1'b0;
      rd_have_q <= 1'b0;
    end else if (clr_i) begin
      wr_q      <= '0;
      done_q    <= DONE_INIT;
      rd_q      <= RD_INIT;
      have_q    <= 1'b0;
      rd_have_q <= 1'b0;
    end else begin
      if (start_i) wr_q <= pick;
      if (done_i) begin
        done_q <= wr_q;
        have_q <= 1'b1;
      end
      if (latch_i) begin
        if (done_i) begin
          rd_q      <= wr_q;
          rd_have_q <= 1'b1;
        end else if (have_q) begin
          rd_q      <= done_q;
          rd_have_q <= 1'b1;
        end
      end
    end
  end

  assign wr_slot_o   = wr_q;
  assign done_slot_o = done_q;
  assign rd_slot_o   = rd_q;
  assign rd_have_o   = rd_have_q;
endmodule

// File: rtl/tbm_read_sel.sv
module tbm_read_sel #(
  parameter int unsigned SW = 2,
  localparam int unsigned BW = SW + 1
) (
  input  logic [SW-1:0] even_slot_i,
  input  logic          even_have_i,
  input  logic [SW-1:0] odd_slot_i,
  input  logic          odd_have_i,
  output logic [BW-1:0] rd_even_o,
  output logic [BW-1:0] rd_odd_o,
  output logic          rd_valid_o
);
  import tbm_pkg::*;
  logic [BW-1:0] even_code, odd_code;

  assign even_code = {PAR_EVEN, even_slot_i};
  assign odd_code  = {PAR_ODD,  odd_slot_i};

  // missing parity falls back to the one that exists
  always_comb begin
    rd_even_o = '0;
    rd_odd_o  = '0;
    if (even_have_i) rd_even_o = even_code;
    else if (odd_have_i) rd_even_o = odd_code;
    if (odd_have_i) rd_odd_o = odd_code;
    else if (even_have_i) rd_odd_o = even_code;
  end

  assign rd_valid_o = even_have_i | odd_have_i;
endmodule

// File: rtl/field_tbuf_mgr.sv
module field_tbuf_mgr #(
  parameter int unsigned SLOTS = 3,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned BW = SW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          interlaced_i,
  input  logic          wr_start_i,
  input  logic          wr_field_i,
  input  logic          wr_done_i,
  input  logic          rd_frame_i,
  output logic [BW-1:0] wr_buf_o,
  output logic [BW-1:0] rd_even_o,
  output logic [BW-1:0] rd_odd_o,
  output logic          rd_valid_o
);
  import tbm_pkg::*;

  logic          mode_q, clr, cur_par_q, wr_active_q, start_par;
  logic [SW-1:0] wr_slot   [NUM_PAR];
  logic [SW-1:0] done_slot [NUM_PAR];
  logic [SW-1:0] rd_slot   [NUM_PAR];
  logic          rd_have   [NUM_PAR];

  assign clr       = interlaced_i != mode_q;
  assign start_par = interlaced_i ? wr_field_i : PAR_EVEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b0;
      cur_par_q   <= PAR_EVEN;
      wr_active_q <= 1'b0;
    end else begin
      mode_q <= interlaced_i;
      if (clr) begin
        cur_par_q   <= PAR_EVEN;
        wr_active_q <= 1'b0;
      end else if (wr_start_i) begin
        cur_par_q   <= start_par;
        wr_active_q <= 1'b1;
      end else if (wr_done_i) begin
        wr_active_q <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAR; p++) begin : g_par
    logic st, dn;
    assign st = wr_start_i && !clr && (start_par == p[0]);
    assign dn = wr_done_i && wr_active_q && !clr && (cur_par_q == p[0]);
    tbm_slot_ring #(.SLOTS(SLOTS)) u_ring (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .start_i    (st),
      .done_i     (dn),
      .latch_i    (rd_frame_i && !clr),
      .wr_slot_o  (wr_slot[p]),
      .done_slot_o(done_slot[p]),
      .rd_slot_o  (rd_slot[p]),
      .rd_have_o  (rd_have[p])
    );
  end

  assign wr_buf_o = {cur_par_q, wr_slot[cur_par_q]};

  tbm_read_sel #(.SW(SW)) u_sel (
    .even_slot_i(rd_slot[PAR_EVEN]),
    .even_have_i(rd_have[PAR_EVEN]),
    .odd_slot_i (rd_slot[PAR_ODD]),
    .odd_have_i (rd_have[PAR_ODD]),
    .rd_even_o  (rd_even_o),
    .rd_odd_o   (rd_odd_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/tbm_checker.sv
module tbm_checker #(
  parameter int unsigned SLOTS = 3,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned BW = SW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_frame_i,
  input logic          clr_i,
  input logic          mode_i,
  input logic          active_i,
  input logic [SW-1:0] cur_wr_i,
  input logic [SW-1:0] cur_rd_i,
  input logic [SW-1:0] cur_done_i,
  input logic [BW-1:0] wr_buf_o,
  input logic [BW-1:0] rd_even_o,
  input logic [BW-1:0] rd_odd_o,
  input logic          rd_valid_o
);
  a_r4_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cur_wr_i != cur_rd_i) && (cur_wr_i != cur_done_i));

  a_r3_hold_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_frame_i && !clr_i) |=> ($stable(rd_even_o) && $stable(rd_odd_o) && $stable(rd_valid_o)));

  a_r7_mode_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!rd_valid_o && wr_buf_o == '0 && rd_even_o == '0 && rd_odd_o == '0));

  a_r6_prog_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (rd_even_o == rd_odd_o && !wr_buf_o[BW-1]));

  a_r2_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_buf_o[SW-1:0]) < SLOTS);

  a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !clr_i) |=> rd_valid_o);
endmodule

bind field_tbuf_mgr tbm_checker #(.SLOTS(SLOTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_frame_i(rd_frame_i),
  .clr_i     (clr),
  .mode_i    (mode_q),
  .active_i  (wr_active_q),
  .cur_wr_i  (wr_slot[cur_par_q]),
  .cur_rd_i  (rd_slot[cur_par_q]),
  .cur_done_i(done_slot[cur_par_q]),
  .wr_buf_o  (wr_buf_o),
  .rd_even_o (rd_even_o),
  .rd_odd_o  (rd_odd_o),
  .rd_valid_o(rd_valid_o)
);

// File: tb/field_tbuf_mgr_test.sv
module field_tbuf_mgr_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic interlaced, wr_start, wr_field, wr_done, rd_frame;
  logic [2:0] wr_buf, rd_even, rd_odd;
  logic rd_valid;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  field_tbuf_mgr uut (
    .clk_i(clk), .rst_ni(rst_ni), .interlaced_i(interlaced),
    .wr_start_i(wr_start), .wr_field_i(wr_field), .wr_done_i(wr_done),
    .rd_frame_i(rd_frame), .wr_buf_o(wr_buf), .rd_even_o(rd_even),
    .rd_odd_o(rd_odd), .rd_valid_o(rd_valid)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input int ev, input int od, input int vl);
    chk({tag, " even"}, rd_even, ev);
    chk({tag, " odd"}, rd_odd, od);
    chk({tag, " valid"}, rd_valid, vl);
  endtask

  task automatic do_reset(input logic il);
    @(negedge clk);
    rst_ni = 1'b0; interlaced = il;
    wr_start = 0; wr_field = 0; wr_done = 0; rd_frame = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_f(input logic f);
    wr_start = 1; wr_field = f; @(negedge clk); wr_start = 0;
  endtask
  task automatic done_f();
    wr_done = 1; @(negedge clk); wr_done = 0;
  endtask
  task automatic frame();
    rd_frame = 1; @(negedge clk); rd_frame = 0;
  endtask
  task automatic done_frame();
    wr_done = 1; rd_frame = 1; @(negedge clk); wr_done = 0; rd_frame = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_ni = 1'b0; interlaced = 1;
    wr_start = 0; wr_field = 0; wr_done = 0; rd_frame = 0;
    #1;
    chk("R1 wr_buf in reset", wr_buf, 0);
    chk_rd("R1 reset", 0, 0, 0);
    do_reset(1);
    chk("R1 wr_buf after reset", wr_buf, 0);
    chk_rd("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_weave();
    do_reset(1);
    start_f(0); chk("R2 first even pick", wr_buf, 0);
    done_f(); chk_rd("R3 done not yet visible", 0, 0, 0);
    frame(); chk_rd("R5 even only fallback", 0, 0, 1);
    start_f(1); chk("R2 first odd pick", wr_buf, 4);
    done_f(); chk_rd("R3 stable between frames", 0, 0, 1);
    frame(); chk_rd("R3 weave both parities", 0, 4, 1);
    start_f(0); chk("R2 even skips held", wr_buf, 1);
    done_f(); frame(); chk_rd("R3 field rate update", 1, 4, 1);
    start_f(1); chk("R2 odd skips held", wr_buf, 5);
    done_f();
    start_f(0); chk("R2 even pick 0", wr_buf, 0);
    done_f();
    start_f(1); chk("R4 odd avoids rd and done", wr_buf, 6);
    frame(); chk_rd("R3 latest of each parity", 0, 5, 1);
    done_f(); chk_rd("R3 hold after done", 0, 5, 1);
    start_f(0); chk("R4 even avoids held", wr_buf, 1);
  endtask

  task automatic t_odd_first();
    do_reset(1);
    start_f(1); chk("R2 odd parity bit", wr_buf, 4);
    done_f(); frame(); chk_rd("R5 odd only fallback", 4, 4, 1);
  endtask

  task automatic t_same_cycle();
    do_reset(1);
    start_f(0); done_frame(); chk_rd("R8 same cycle handover", 0, 0, 1);
    start_f(0); chk("R8 next pick", wr_buf, 1);
    done_frame(); chk_rd("R8 second handover", 1, 1, 1);
  endtask

  task automatic t_progressive();
    do_reset(0);
    start_f(1); chk("R6 field ignored", wr_buf, 0);
    done_f(); frame(); chk_rd("R6 both equal", 0, 0, 1);
    start_f(1); chk("R6 rotation", wr_buf, 1);
    done_f(); frame(); chk_rd("R6 both equal again", 1, 1, 1);
  endtask

  task automatic t_mode_flip();
    do_reset(1);
    start_f(1); done_f(); frame();
    start_f(1); chk("R7 pre flip wr", wr_buf, 5);
    interlaced = 0; rd_frame = 1; wr_done = 1;
    @(negedge clk); rd_frame = 0; wr_done = 0;
    chk("R7 wr_buf cleared", wr_buf, 0);
    chk_rd("R7 reader cleared", 0, 0, 0);
    frame(); chk_rd("R7 nothing finished after flip", 0, 0, 0);
  endtask

  initial begin
    interlaced = 1; wr_start = 0; wr_field = 0; wr_done = 0; rd_frame = 0;
    t_reset();
    t_weave();
    t_odd_first();
    t_same_cycle();
    t_progressive();
    t_mode_flip();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule